// File: doc/BRIEF.md
# Parallel Video Word Unpacker

This block sits behind a 7:1 deserializer and its clock-lane aligner. Each link cycle, the deserializer hands over four 7-bit lane words, 28 bits in all. The block rebuilds a registered parallel video bus from them: a 24-bit pixel value, the frame-valid, line-valid and data-valid flags, and one spare control bit. A fixed position table in the package says which bundle bits carry framing. Every other bundle bit is a pixel bit, taken in ascending order.

The block also keeps two counters for checking the picture geometry. One counts the valid pixels of the current line. The other counts the lines completed in the current frame. Nothing is unpacked while the aligner reports that it is not locked. When the lock drops, every valid output falls in that same cycle and both counters go back to zero.

Top module: `video_word_unpacker`

## Requirements
- R1: Lane word i occupies bits 7i+6..7i of `laneWords`. In the 28-bit bundle, bits 23..0 are pixel bits 23..0. Bit 24 is frame valid, bit 25 is line valid, bit 26 is data valid and bit 27 is the spare bit.
- R2: Take an accepted word (`wordValid` and `lockIn` high) whose frame, line and data valid bits are all 1. One cycle later, `pixData` shows its 24 pixel bits and `pixValid` is 1.
- R3: If an accepted word has any of frame, line or data valid at 0, then one cycle later `pixValid` is 0 and `pixData` keeps its previous value.
- R4: A cycle with `wordValid` low changes none of the flags, pixel data or counters, and drives `pixValid` to 0 in the next cycle.
- R5: `frameValid`, `lineValid`, `dataValid` and `spareBit` show the corresponding bits of the last accepted word, one cycle after it was accepted.
- R6: `pixCount` counts the words passed out as pixels since the last rising edge of line valid. An accepted word that raises line valid restarts the count at 1 if the word is a pixel, and at 0 otherwise.
- R7: `lineCount` goes up by one for each accepted word that drops line valid. An accepted word that raises frame valid clears it to 0, and this takes priority.
- R8: While `lockIn` is 0, `pixValid`, `frameValid`, `lineValid`, `dataValid`, `spareBit`, `pixCount` and `lineCount` are all 0 in that same cycle, and incoming words are ignored. After relock, the previous flags count as 0 for edge detection. `pixData` keeps its value.
- R9: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link-rate parallel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lockIn | input | 1 | Aligner has found the clock-lane pattern |
| wordValid | input | 1 | The lane words are valid this cycle |
| laneWords | input | 28 | Four 7-bit lane words, lane 0 in the low bits |
| pixData | output | 24 | Registered pixel value |
| pixValid | output | 1 | pixData is a new pixel this cycle |
| frameValid | output | 1 | Recovered frame-valid flag |
| lineValid | output | 1 | Recovered line-valid flag |
| dataValid | output | 1 | Recovered data-valid flag |
| spareBit | output | 1 | Recovered spare control bit |
| pixCount | output | 12 | Pixels in the current line |
| lineCount | output | 12 | Completed lines in the current frame |

## Verification
The bench walks a single 1 across every pixel bit through the lane words. A swapped lane or an off-by-one bit map shows up as a wrong `pixData`. It sends frames of different heights and widths, with data-valid holes and word gaps in the lines. A design that counts flagged-off words, or that treats a gap as a line edge, ends up with wrong pixel and line counts. It also checks the case where a line starts with data valid low, which should restart the count at 0, not 1. Finally, it drops the lock in the middle of a line and samples the outputs before the next clock edge. A design that only clears registers sees its flags linger for one cycle. After relock, a design that keeps stale edge history misses the restart of the pixel count.

// File: rtl/vwu_pkg.sv
package vwu_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 7;
  localparam int BUS_W  = LANES * LANE_W;
  localparam int CTRL_N = 4;
  localparam int PIX_W  = BUS_W - CTRL_N;

  // framing bit slots: index 0 frame, 1 line, 2 data, 3 spare
  localparam int FLAG_FV = 0;
  localparam int FLAG_LV = 1;
  localparam int FLAG_DV = 2;
  localparam int FLAG_SP = 3;
  localparam int CTRL_POS [CTRL_N] = '{24, 25, 26, 27};

  typedef struct packed {
    logic accept;
    logic flush;
    logic pixLoad;
    logic pixRestart;
    logic lineClr;
    logic lineInc;
  } strobe_t;

  function automatic bit isCtrlPos(int pos);
    bit hit;
    hit = 1'b0;
    for (int c = 0; c < CTRL_N; c++)
      if (CTRL_POS[c] == pos) hit = 1'b1;
    return hit;
  endfunction

  // bundle position of the k-th pixel bit (ascending over non-framing bits)
  function automatic int pixPos(int k);
    int seen;
    int found;
    seen  = 0;
    found = 0;
    for (int i = 0; i < BUS_W; i++) begin
      if (!isCtrlPos(i)) begin
        if (seen == k) found = i;
        seen++;
      end
    end
    return found;
  endfunction
endpackage

// File: rtl/vwu_ctrl.sv
module vwu_ctrl
  import vwu_pkg::*;
(
  input  logic    lockIn,
  input  logic    wordValid,
  input  logic    fvIn,
  input  logic    lvIn,
  input  logic    dvIn,
  input  logic    fvPrev,
  input  logic    lvPrev,
  output strobe_t strobe
);
  logic accept;

  assign accept = lockIn & wordValid;

  always_comb begin
    strobe            = '0;
    strobe.accept     = accept;
    strobe.flush      = ~lockIn;
    strobe.pixLoad    = accept & fvIn & lvIn & dvIn;
    strobe.pixRestart = accept & lvIn & ~lvPrev;
    strobe.lineClr    = accept & fvIn & ~fvPrev;
    strobe.lineInc    = accept & ~lvIn & lvPrev;
  end
endmodule

// File: rtl/vwu_dpath.sv
module vwu_dpath
  import vwu_pkg::*;
#(
  parameter int PIX_CNT_W  = 12,
  parameter int LINE_CNT_W = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strobe,
  input  logic [BUS_W-1:0]      bundle,
  output logic [CTRL_N-1:0]     flagsOut,
  output logic                  pixValidOut,
  output logic [PIX_W-1:0]      pixDataOut,
  output logic [PIX_CNT_W-1:0]  pixCntOut,
  output logic [LINE_CNT_W-1:0] lineCntOut
);
  logic [PIX_W-1:0]      pixWord;
  logic [CTRL_N-1:0]     flagWord;
  logic [CTRL_N-1:0]     flagsR;
  logic                  pixValidR;
  logic [PIX_W-1:0]      pixDataR;
  logic [PIX_CNT_W-1:0]  pixCntR;
  logic [LINE_CNT_W-1:0] lineCntR;

  for (genvar g = 0; g < PIX_W; g++) begin : g_pix
    assign pixWord[g] = bundle[pixPos(g)];
  end
  for (genvar c = 0; c < CTRL_N; c++) begin : g_flag
    assign flagWord[c] = bundle[CTRL_POS[c]];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsR    <= '0;
      pixValidR <= 1'b0;
      pixDataR  <= '0;
      pixCntR   <= '0;
      lineCntR  <= '0;
    end else if (strobe.flush) begin
      flagsR    <= '0;
      pixValidR <= 1'b0;
      pixCntR   <= '0;
      lineCntR  <= '0;
    end else begin
      pixValidR <= strobe.pixLoad;
      if (strobe.accept) flagsR <= flagWord;
      if (strobe.pixLoad) pixDataR <= pixWord;
      if (strobe.pixRestart)
        pixCntR <= PIX_CNT_W'(strobe.pixLoad);
      else if (strobe.pixLoad)
        pixCntR <= pixCntR + 1'b1;
      if (strobe.lineClr)
        lineCntR <= '0;
      else if (strobe.lineInc)
        lineCntR <= lineCntR + 1'b1;
    end
  end

  assign flagsOut    = flagsR;
  assign pixValidOut = pixValidR;
  assign pixDataOut  = pixDataR;
  assign pixCntOut   = pixCntR;
  assign lineCntOut  = lineCntR;

  // R3
  no_load_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.pixLoad |=> $stable(pixDataR));

  // R6
  pix_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.flush && !strobe.pixRestart) |=>
      (pixCntR == $past(pixCntR)) || (pixCntR == $past(pixCntR) + 1'b1));

  // R7
  line_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.flush && strobe.lineClr) |=> (lineCntR == '0));
endmodule

// File: rtl/video_word_unpacker.sv
module video_word_unpacker
  import vwu_pkg::*;
#(
  parameter int PIX_CNT_W  = 12,
  parameter int LINE_CNT_W = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  lockIn,
  input  logic                  wordValid,
  input  logic [BUS_W-1:0]      laneWords,
  output logic [PIX_W-1:0]      pixData,
  output logic                  pixValid,
  output logic                  frameValid,
  output logic                  lineValid,
  output logic                  dataValid,
  output logic                  spareBit,
  output logic [PIX_CNT_W-1:0]  pixCount,
  output logic [LINE_CNT_W-1:0] lineCount
);
  strobe_t               strobe;
  logic [CTRL_N-1:0]     flagsR;
  logic                  pixValidR;
  logic [PIX_CNT_W-1:0]  pixCntR;
  logic [LINE_CNT_W-1:0] lineCntR;

  vwu_ctrl u_ctrl (
    .lockIn   (lockIn),
    .wordValid(wordValid),
    .fvIn     (laneWords[CTRL_POS[FLAG_FV]]),
    .lvIn     (laneWords[CTRL_POS[FLAG_LV]]),
    .dvIn     (laneWords[CTRL_POS[FLAG_DV]]),
    .fvPrev   (flagsR[FLAG_FV]),
    .lvPrev   (flagsR[FLAG_LV]),
    .strobe   (strobe)
  );

  vwu_dpath #(.PIX_CNT_W(PIX_CNT_W), .LINE_CNT_W(LINE_CNT_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .bundle     (laneWords),
    .flagsOut   (flagsR),
    .pixValidOut(pixValidR),
    .pixDataOut (pixData),
    .pixCntOut  (pixCntR),
    .lineCntOut (lineCntR)
  );

  assign frameValid = flagsR[FLAG_FV] & lockIn;
  assign lineValid  = flagsR[FLAG_LV] & lockIn;
  assign dataValid  = flagsR[FLAG_DV] & lockIn;
  assign spareBit   = flagsR[FLAG_SP] & lockIn;
  assign pixValid   = pixValidR & lockIn;
  assign pixCount   = lockIn ? pixCntR : '0;
  assign lineCount  = lockIn ? lineCntR : '0;

  // R2
  pix_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> $past(wordValid && lockIn && laneWords[CTRL_POS[FLAG_FV]]
                       && laneWords[CTRL_POS[FLAG_LV]] && laneWords[CTRL_POS[FLAG_DV]]));

  // R4
  gap_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wordValid && lockIn) |=> (!pixValid && (!lockIn || $stable(lineCount))));

  // R8
  unlock_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lockIn |-> (!pixValid && !frameValid && !lineValid && pixCount == '0));

  // R8
  unlock_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!lockIn && $past(!lockIn)) |-> (pixCntR == '0 && lineCntR == '0));
endmodule

// File: tb/tb_video_word_unpacker.sv
module tb_video_word_unpacker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lockIn = 1'b0;
  logic        wordValid = 1'b0;
  logic [27:0] laneWords = '0;
  logic [23:0] pixData;
  logic        pixValid, frameValid, lineValid, dataValid, spareBit;
  logic [11:0] pixCount, lineCount;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic        mFv = 0, mLv = 0, mDv = 0, mSp = 0, mPixV = 0;
  logic [23:0] mPix = '0;
  int          mPixCnt = 0, mLineCnt = 0;

  video_word_unpacker dut (
    .clk(clk), .rstN(rstN), .lockIn(lockIn), .wordValid(wordValid),
    .laneWords(laneWords), .pixData(pixData), .pixValid(pixValid),
    .frameValid(frameValid), .lineValid(lineValid), .dataValid(dataValid),
    .spareBit(spareBit), .pixCount(pixCount), .lineCount(lineCount)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    chk(req, "frameValid", int'(frameValid), lockIn ? int'(mFv) : 0);
    chk(req, "lineValid",  int'(lineValid),  lockIn ? int'(mLv) : 0);
    chk(req, "dataValid",  int'(dataValid),  lockIn ? int'(mDv) : 0);
    chk(req, "spareBit",   int'(spareBit),   lockIn ? int'(mSp) : 0);
    chk(req, "pixValid",   int'(pixValid),   lockIn ? int'(mPixV) : 0);
    chk(req, "pixData",    int'(pixData),    int'(mPix));
    chk(req, "pixCount",   int'(pixCount),   lockIn ? mPixCnt : 0);
    chk(req, "lineCount",  int'(lineCount),  lockIn ? mLineCnt : 0);
  endtask

  // one link cycle; bundle built per R1: {spare, dv, lv, fv, pixel}
  task automatic step(string req, logic wv, logic lk, logic fv, logic lv,
                      logic dv, logic sp, logic [23:0] pix);
    logic v;
    @(negedge clk);
    wordValid = wv;
    lockIn    = lk;
    laneWords = {sp, dv, lv, fv, pix};
    @(posedge clk);
    if (!lk) begin
      mFv = 0; mLv = 0; mDv = 0; mSp = 0; mPixV = 0;
      mPixCnt = 0; mLineCnt = 0;
    end else if (wv) begin
      v = fv & lv & dv;
      if (lv && !mLv) mPixCnt = int'(v);
      else            mPixCnt = mPixCnt + int'(v);
      if (fv && !mFv)      mLineCnt = 0;
      else if (!lv && mLv) mLineCnt = mLineCnt + 1;
      if (v) mPix = pix;
      mPixV = v;
      mFv = fv; mLv = lv; mDv = dv; mSp = sp;
    end else begin
      mPixV = 0;
    end
    #1;
    checkAll(req);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R9: reset state
    #(CLK_PERIOD * 3);
    #1;
    checkAll("R9");
    @(negedge clk);
    rstN = 1'b1;
    lockIn = 1'b1;

    // R1: walking one over every pixel bit, placed lane by lane
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      wordValid = 1'b1;
      laneWords = '0;
      laneWords[7*(k/7) + (k%7)] = 1'b1;
      laneWords[7*3 + 3] = 1'b1;  // lane 3 bit 3 = frame valid
      laneWords[7*3 + 4] = 1'b1;  // lane 3 bit 4 = line valid
      laneWords[7*3 + 5] = 1'b1;  // lane 3 bit 5 = data valid
      @(posedge clk);
      #1;
      chk("R1", "pixData walk", int'(pixData), 1 << k);
      chk("R2", "pixValid walk", int'(pixValid), 1);
      chk("R6", "pixCount walk", int'(pixCount), k + 1);
    end
    // keep model in sync: close that line and frame
    mFv = 1; mLv = 1; mDv = 1; mSp = 0; mPixV = 1;
    mPix = 24'h800000; mPixCnt = 24; mLineCnt = 0;
    step("R7", 1, 1, 1, 0, 0, 0, 24'h0);
    step("R5", 1, 1, 0, 0, 0, 1, 24'h0);

    // R2/R3/R4/R6/R7: frames of varying geometry
    for (int f = 0; f < 3; f++) begin
      step("R5", 1, 1, 1, 0, 0, f[0], 24'h0);
      for (int l = 0; l < f + 2; l++) begin
        for (int p = 0; p < 3 + f; p++) begin
          step("R2", 1, 1, 1, 1, 1, 0, 24'(f * 4096 + l * 256 + p * 17 + 5));
          if (p == 1) step("R3", 1, 1, 1, 1, 0, 0, 24'hABCDEF);
          if (p == 2) step("R4", 0, 1, 0, 0, 0, 1, 24'h123456);
        end
        step("R7", 1, 1, 1, 0, 0, 1, 24'h0);
        step("R7", 1, 1, 1, 0, 0, 0, 24'h0);
      end
      chk("R7", "lines per frame", int'(lineCount), f + 2);
      step("R5", 1, 1, 0, 0, 0, 0, 24'h0);
    end

    // R6: line opening with data valid low restarts count at zero
    step("R7", 1, 1, 1, 0, 0, 0, 24'h0);
    step("R6", 1, 1, 1, 1, 0, 0, 24'h0);
    chk("R6", "restart at zero", int'(pixCount), 0);
    step("R6", 1, 1, 1, 1, 1, 1, 24'h0F0F0F);
    step("R6", 1, 1, 1, 1, 1, 0, 24'hF0F0F0);
    chk("R6", "count after restart", int'(pixCount), 2);

    // R8: lock drops mid-line, outputs fall before the next edge
    @(negedge clk);
    lockIn = 1'b0;
    #1;
    chk("R8", "frameValid same cycle", int'(frameValid), 0);
    chk("R8", "lineValid same cycle", int'(lineValid), 0);
    chk("R8", "pixValid same cycle", int'(pixValid), 0);
    chk("R8", "pixCount same cycle", int'(pixCount), 0);
    for (int i = 0; i < 4; i++)
      step("R8", 1, 0, 1, 1, 1, 1, 24'h555555);
    chk("R8", "pixData kept", int'(pixData), 24'hF0F0F0);
    // relock inside a line: edge history cleared, count restarts
    step("R8", 1, 1, 1, 1, 1, 0, 24'h777777);
    chk("R8", "count after relock", int'(pixCount), 1);
    step("R8", 1, 1, 1, 1, 1, 0, 24'h888888);
    step("R7", 1, 1, 1, 0, 0, 0, 24'h0);
    chk("R7", "line after relock", int'(lineCount), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule